// File: doc/BRIEF.md
# Latched Prioritized Interrupt Request Unit

This block keeps eight sticky interrupt-request flags and tells the CPU which one to take next. A one-cycle set pulse from a source (external pin, timer overflow, serial receive, software trap) raises a flag. The flag stays up after the source event has gone. Only an explicit clear strobe for that line removes it, or the source's peripheral enable going low. Servicing an interrupt leaves the flag untouched. Software clears it later, and may also cancel a pending request before it is ever taken.

Each cycle the unit finds the highest-numbered pending line and registers two results: its index and a request-valid flag. The valid flag is held low while the global inhibit input is high. The unit keeps no record of which priority is being serviced. Once inhibit drops again, whatever is pending is offered, even a line of lower priority than the one being serviced. Vector fetch and return-address handling belong to the CPU and are not part of this block.

Top module: `irq_unit`

## Requirements
- R1: There are eight flags, one per line 0..7. A set pulse on line i while its peripheral is enabled makes `pending_o[i]` 1 one clock later, and the flag stays 1 after the pulse ends.
- R2: A clear strobe on line i with no set pulse on line i drops `pending_o[i]` one clock later and leaves every other line unchanged.
- R3: When the set pulse and the clear strobe of one enabled line arrive in the same cycle, the flag is 1 afterwards.
- R4: Lines are grouped by peripheral through bit k of `periph_en_i`:
  - group 0 (pins) holds lines 0, 6 and 7;
  - group 1 (timers) holds lines 1, 2 and 5;
  - group 2 (serial receive) holds line 3;
  - group 3 (trap) holds line 4.
  While a group's enable bit is 0, its lines read 0 one clock later and set pulses on them are ignored.
- R5: Priority rises with the line number. `req_idx_o` names the highest set bit of `pending_o`.
- R6: `req_valid_o` is 1 exactly when `pending_o` is nonzero and `inhibit_i` was 0 in the cycle before. Inhibit has no effect on the flags.
- R7: With no flag pending, `req_valid_o` is 0 and `req_idx_o` is 0.
- R8: `pending_o`, `req_idx_o` and `req_valid_o` are registered and updated together on every clock. Reset makes all of them 0.
- R9: There is no memory of the line last selected. After a higher line is cleared, a pending lower line is offered on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_pulse_i | input | 8 | Per-line source event pulses |
| clr_strobe_i | input | 8 | Per-line clear strobes |
| periph_en_i | input | 4 | Per-peripheral interrupt enables |
| inhibit_i | input | 1 | Global interrupt inhibit |
| pending_o | output | 8 | Latched pending flags |
| req_valid_o | output | 1 | A request is offered to the CPU |
| req_idx_o | output | 3 | Index of the offered line |

## Verification
The hardest case to reach from the ports is a set pulse and a clear strobe on the same line in the same cycle while that line's enable is high. A second hard case is an enable that drops in the same cycle as a set pulse on one of its lines. Random stimulus produces both of these only rarely. The bench therefore drives them as directed steps, and it also weights the random phase so that sets, clears and enable drops overlap often. A further directed sequence holds several lines pending, clears them from the top down and checks that the offered index walks down line by line.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
    localparam int unsigned IRQ_LINES  = 8;
    localparam int unsigned IRQ_GROUPS = 4;
    // Line-to-group map, two bits per line, line 0 in the low bits.
    // Lines 7..0 -> groups 0,0,1,3,2,1,1,0
    localparam logic [15:0] IRQ_GROUP_MAP = 16'h0794;
endpackage

// File: rtl/irq_grp_mask.sv
module irq_grp_mask #(
    parameter int unsigned N  = 8,
    parameter int unsigned G  = 4,
    parameter int unsigned GW = (G > 1) ? $clog2(G) : 1,
    parameter logic [N*GW-1:0] MAP = '0
) (
    input  logic [G-1:0] grp_en_i,
    output logic [N-1:0] line_en_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign line_en_o[i] = grp_en_i[MAP[i*GW +: GW]];
    end
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] pend_d_o,
    output logic [N-1:0] pend_q_o
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (!en_i[i])
                pend_d[i] = 1'b0;
            else if (set_i[i])
                pend_d[i] = 1'b1;
            else if (clr_i[i])
                pend_d[i] = 1'b0;
            else
                pend_d[i] = pend_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_d_o = pend_d;
    assign pend_q_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
    parameter int unsigned N     = irq_unit_pkg::IRQ_LINES,
    parameter int unsigned G     = irq_unit_pkg::IRQ_GROUPS,
    parameter int unsigned GW    = (G > 1) ? $clog2(G) : 1,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
    parameter logic [N*GW-1:0] GROUP_MAP = irq_unit_pkg::IRQ_GROUP_MAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     set_pulse_i,
    input  logic [N-1:0]     clr_strobe_i,
    input  logic [G-1:0]     periph_en_i,
    input  logic             inhibit_i,
    output logic [N-1:0]     pending_o,
    output logic             req_valid_o,
    output logic [IDX_W-1:0] req_idx_o
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } sel_t;

    logic [N-1:0]     line_en;
    logic [N-1:0]     pend_d;
    logic             any_d;
    logic [IDX_W-1:0] idx_d;
    sel_t             sel_d, sel_q;

    irq_grp_mask #(.N(N), .G(G), .GW(GW), .MAP(GROUP_MAP)) u_mask (
        .grp_en_i (periph_en_i),
        .line_en_o(line_en)
    );

    irq_latch_bank #(.N(N)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_pulse_i),
        .clr_i   (clr_strobe_i),
        .en_i    (line_en),
        .pend_d_o(pend_d),
        .pend_q_o(pending_o)
    );

    irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .vec_i(pend_d),
        .any_o(any_d),
        .idx_o(idx_d)
    );

    always_comb begin
        sel_d       = '0;
        sel_d.valid = any_d && !inhibit_i;
        sel_d.idx   = idx_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign req_valid_o = sel_q.valid;
    assign req_idx_o   = sel_q.idx;
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
    parameter int unsigned N     = 8,
    parameter int unsigned G     = 4,
    parameter int unsigned IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     set_pulse_i,
    input logic [N-1:0]     clr_strobe_i,
    input logic             inhibit_i,
    input logic [N-1:0]     line_en,
    input logic [N-1:0]     pending_o,
    input logic             req_valid_o,
    input logic [IDX_W-1:0] req_idx_o
);
    // R1: enabled set pulse yields a pending flag
    a_r1_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_o & $past(set_pulse_i & line_en)) == $past(set_pulse_i & line_en)));
    // R2: a flag only drops via clear strobe or enable
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_o & $past(pending_o & ~clr_strobe_i & line_en))
                  == $past(pending_o & ~clr_strobe_i & line_en)));
    // R1: no flag rises without a set pulse
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_o & ~$past(pending_o) & ~$past(set_pulse_i)) == '0));
    // R4: disabled lines are empty
    a_r4_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending_o & ~$past(line_en)) == '0));
    // R6: inhibit suppresses the request
    a_r6_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> !req_valid_o);
    // R6: valid implies something pending
    a_r6_valid_pending: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (pending_o != '0));
    // R5: offered line is the top pending line
    a_r5_top_line: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> ((pending_o >> req_idx_o) == N'(1)));
endmodule

bind irq_unit irq_unit_chk #(.N(N), .G(G), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_pulse_i (set_pulse_i),
    .clr_strobe_i(clr_strobe_i),
    .inhibit_i   (inhibit_i),
    .line_en     (line_en),
    .pending_o   (pending_o),
    .req_valid_o (req_valid_o),
    .req_idx_o   (req_idx_o)
);

// File: tb/sim_irq_unit.sv
`timescale 1ns/1ps
module sim_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] set_p = '0, clr_s = '0;
    logic [3:0] pen = '0;
    logic       inh = 1'b0;
    logic [7:0] pend;
    logic       vld;
    logic [2:0] idx;

    int checks = 0, errors = 0;
    logic [7:0] m_pend = '0;
    logic       m_vld  = 1'b0;
    logic [2:0] m_idx  = '0;

    always #10 clk = ~clk;

    irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .set_pulse_i(set_p), .clr_strobe_i(clr_s),
        .periph_en_i(pen), .inhibit_i(inh), .pending_o(pend),
        .req_valid_o(vld), .req_idx_o(idx)
    );

    function automatic logic [7:0] line_en_of(input logic [3:0] g);
        logic [7:0] e;
        e[0] = g[0]; e[6] = g[0]; e[7] = g[0];
        e[1] = g[1]; e[2] = g[1]; e[5] = g[1];
        e[3] = g[2]; e[4] = g[3];
        return e;
    endfunction

    function automatic logic [2:0] top_of(input logic [7:0] v);
        logic [2:0] r = '0;
        for (int i = 0; i < 8; i++) if (v[i]) r = 3'(i);
        return r;
    endfunction

    task automatic cmp(input string tag);
        checks++;
        if (pend !== m_pend || vld !== m_vld || idx !== m_idx) begin
            errors++;
            $display("FAIL %s: pend=%b vld=%b idx=%0d expected pend=%b vld=%b idx=%0d",
                     tag, pend, vld, idx, m_pend, m_vld, m_idx);
        end
    endtask

    task automatic step(input logic [7:0] s, input logic [7:0] c,
                        input logic [3:0] g, input logic ih, input string tag);
        set_p = s; clr_s = c; pen = g; inh = ih;
        m_pend = ((m_pend & ~c) | s) & line_en_of(g);
        m_vld  = (m_pend != 0) && !ih;
        m_idx  = top_of(m_pend);
        @(posedge clk); #1;
        cmp(tag);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        #1;
        cmp("R8 reset");
        rst_n = 1'b1;
        // R1: set then hold
        step(8'h04, 8'h00, 4'hF, 1'b0, "R1 set line2");
        step(8'h00, 8'h00, 4'hF, 1'b0, "R1 hold line2");
        // R5: higher line wins
        step(8'h81, 8'h00, 4'hF, 1'b0, "R5 line7 wins");
        // R6: inhibit hides request, flags stay
        step(8'h00, 8'h00, 4'hF, 1'b1, "R6 inhibit");
        step(8'h00, 8'h00, 4'hF, 1'b0, "R6 release");
        // R9/R2: clear top, lower offered
        step(8'h00, 8'h80, 4'hF, 1'b0, "R9 clear 7 -> 2");
        step(8'h00, 8'h04, 4'hF, 1'b0, "R2 clear 2 -> 0");
        // R3: set and clear same cycle
        step(8'h10, 8'h10, 4'hF, 1'b0, "R3 set wins");
        // R4: drop timer group, lines 1,2,5
        step(8'h26, 8'h00, 4'hF, 1'b0, "R4 fill timers");
        step(8'h02, 8'h00, 4'hD, 1'b0, "R4 timer disable wipes");
        step(8'h20, 8'h00, 4'hD, 1'b0, "R4 set ignored while off");
        step(8'h00, 8'h00, 4'hF, 1'b0, "R4 re-enable stays empty");
        // R4: trap group and serial group
        step(8'h08, 8'h00, 4'h7, 1'b0, "R4 trap off");
        step(8'h00, 8'h00, 4'h3, 1'b0, "R4 serial off");
        // R7: empty
        step(8'h00, 8'h01, 4'hF, 1'b0, "R7 empty");
        // R9: top-down walk
        step(8'hE7, 8'h00, 4'hF, 1'b1, "R9 load");
        for (int k = 7; k >= 0; k--)
            step(8'h00, 8'(1 << k), 4'hF, 1'b0, "R9 walk down");
        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] s, c;
            logic [3:0] g;
            s = 8'($urandom) & 8'($urandom);
            c = 8'($urandom) & 8'($urandom) & 8'($urandom);
            g = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
            step(s, c, g, ($urandom % 4) == 0, "R8 random");
        end
        rst_n = 1'b0;
        m_pend = '0; m_vld = 1'b0; m_idx = '0;
        @(posedge clk); #1;
        cmp("R8 reset again");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule